// File: doc/BRIEF.md
# Reset Controller Sequencer

This block turns software reset commands and watchdog faults into three reset outputs: a processor reset, a peripheral reset and an active-low external pin reset. Commands are written in the fast master-clock domain. The reset timing itself runs on a slow clock. A command is carried into the slow domain by a toggle, and a two-flop synchroniser brings the slow domain's activity back to the master-clock side.

Internal resets selected by a write assert on the next master-clock edge. They stay asserted until the slow-domain reset state has run for its fixed three slow cycles. Their release therefore follows the slow clock. The external pin pulse runs only on the slow clock. Its length is an exponential function of a small length field that software programs beforehand.

A status flag marks a software command in progress, and writes made while it is set are dropped. A reset-type code records processor software resets and watchdog resets. A watchdog fault that arrives during a software reset is held and is served after that reset ends. A separate output flags every low level on the pin that the block drives itself, so that the pin-sensing logic elsewhere does not read it as a user reset.

Top module: `rstseq_top`

## Requirements
- R1: After both resets are released, proc_rst_n, periph_rst_n and ext_rst_n are high, stat_busy is 0 and stat_type is 0.
- R2: A write with cmd_we=1 and at least one command bit set, made while stat_busy is 0, drives the selected internal resets low at the next mck edge. Unselected internal resets stay high. A write with all three command bits 0 has no effect and leaves stat_busy at 0.
- R3: A software reset holds each selected internal reset low for 3 slow cycles after the slow domain takes the command. Counted on the slow clock from the write, the low time is 4 to 6 slow cycles.
- R4: stat_busy goes to 1 at the mck edge that accepts a command and returns to 0 only after the software reset has ended. Writes made while stat_busy is 1 change no output and do not change stat_type.
- R5: stat_type becomes 3 when an accepted command includes the processor bit. Commands with only the peripheral bit and/or the external bit leave stat_type unchanged.
- R6: When a software or watchdog reset selects the pin, ext_rst_n is low for exactly 2^(L+1) slow cycles, where L is the value last written to mode_len.
- R7: ext_self_low is 1 in exactly the slow cycles in which the block drives ext_rst_n low.
- R8: A watchdog fault with wdt_proc_only=0 holds proc_rst_n and periph_rst_n low for exactly 3 slow cycles and drives the pin for 2^(L+1) slow cycles.
- R9: A watchdog fault with wdt_proc_only=1 holds only proc_rst_n low, for exactly 3 slow cycles. periph_rst_n and ext_rst_n stay high.
- R10: After a watchdog reset, stat_type reads 2.
- R11: A watchdog fault that arrives during a software reset is held and served after that reset, so that proc_rst_n shows two separate low periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mck | input | 1 | Fast master clock (register side) |
| mck_rst_n | input | 1 | Synchronous active-low reset, mck domain |
| slck | input | 1 | Slow clock that times the resets |
| slck_rst_n | input | 1 | Synchronous active-low reset, slck domain |
| cmd_we | input | 1 | Control-register write strobe |
| cmd_proc | input | 1 | Command bit: processor reset |
| cmd_periph | input | 1 | Command bit: peripheral reset |
| cmd_ext | input | 1 | Command bit: external pin reset |
| mode_we | input | 1 | Mode-register write strobe |
| mode_len | input | LEN_W | Pin length exponent L, giving a pulse of 2^(L+1) slow cycles |
| wdt_fault | input | 1 | Watchdog fault pulse, synchronous to slck |
| wdt_proc_only | input | 1 | Watchdog option: processor reset only |
| proc_rst_n | output | 1 | Processor reset, active low |
| periph_rst_n | output | 1 | Peripheral reset, active low |
| ext_rst_n | output | 1 | External pin reset drive, active low |
| ext_self_low | output | 1 | High while the pin low level comes from this block |
| stat_busy | output | 1 | Software command in progress |
| stat_type | output | 3 | Last reset type: 0 none, 2 watchdog, 3 software |

## Verification
The bench builds the block with its default LEN_W of 4, but it only programs length codes 0 to 3. This keeps every pin pulse within 16 slow cycles, so each length can be counted exactly. The slow clock runs seven times slower than the master clock, which puts the synchroniser latency inside a narrow, predictable window. Within these settings the bench sweeps all seven non-zero command combinations and all four short lengths. It also covers both watchdog options, a write made while busy, and a fault that lands inside a software reset, and it works out every expected count from 3 and 2^(L+1).

// File: rtl/rstseq_pkg.sv
// Shared types and codes for the reset sequencer.
// Assumes: nothing beyond plain SystemVerilog.
package rstseq_pkg;

    localparam int TYPE_W = 3;

    // Reset-type codes reported in the status output
    localparam logic [TYPE_W-1:0] RT_NONE = 3'd0;
    localparam logic [TYPE_W-1:0] RT_WDOG = 3'd2;
    localparam logic [TYPE_W-1:0] RT_SOFT = 3'd3;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SW   = 2'd1,
        SQ_WD   = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic proc;
        logic per;
        logic ext;
    } rst_cmd_t;

endpackage

// File: rtl/rstseq_sync.sv
// Multi-flop level synchroniser into the clk domain.
// Assumes: d is a level that stays put for several clk cycles.
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/rstseq_cmd.sv
// Master-clock side: accepts commands, holds the mode field,
// raises the in-progress flag and keeps the reset-type code.
// Assumes: sw_act_s and wd_tgl_s are already synchronised to clk.
module rstseq_cmd
    import rstseq_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  rst_cmd_t          cmd_in,
    input  logic              mode_we,
    input  logic [LEN_W-1:0]  mode_len,
    input  logic              sw_act_s,
    input  logic              wd_tgl_s,
    output rst_cmd_t          cmd_q,
    output logic              pend_q,
    output logic              req_tgl_q,
    output logic              busy_q,
    output logic [TYPE_W-1:0] type_q,
    output logic [LEN_W-1:0]  len_q
);
    logic act_d_q, up_q, wd_d_q;
    logic accept, act_rise, act_fall, wd_evt;

    assign accept   = cmd_we && (|cmd_in) && !busy_q;
    assign act_rise = sw_act_s && !act_d_q;
    assign act_fall = !sw_act_s && act_d_q;
    assign wd_evt   = wd_tgl_s ^ wd_d_q;

    // Edge history for the values returning from the slow domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_d_q <= 1'b0;
            wd_d_q  <= 1'b0;
        end else begin
            act_d_q <= sw_act_s;
            wd_d_q  <= wd_tgl_s;
        end
    end

    // Capture the accepted command and toggle the request line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            req_tgl_q <= 1'b0;
        end else if (accept) begin
            cmd_q     <= cmd_in;
            req_tgl_q <= ~req_tgl_q;
        end
    end

    // Early assertion window: from accept until the slow side takes over
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (accept)   pend_q <= 1'b1;
        else if (act_rise) pend_q <= 1'b0;
    end

    // In-progress flag: set on accept, cleared once the slow state ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            up_q   <= 1'b0;
        end else begin
            if (accept) busy_q <= 1'b1;
            if (act_rise) up_q <= 1'b1;
            if (act_fall && up_q) begin
                up_q   <= 1'b0;
                busy_q <= 1'b0;
            end
        end
    end

    // Reset-type code: processor software command or watchdog
    always_ff @(posedge clk) begin
        if (!rst_n)                     type_q <= RT_NONE;
        else if (accept && cmd_in.proc) type_q <= RT_SOFT;
        else if (wd_evt)                type_q <= RT_WDOG;
    end

    // Mode register holding the pin length exponent
    always_ff @(posedge clk) begin
        if (!rst_n)       len_q <= '0;
        else if (mode_we) len_q <= mode_len;
    end

    // R4: a write made while busy must not disturb the type code
    a_r4_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cmd_we && !wd_evt) |=> $stable(type_q));

    // R5: an accepted processor command reports software type and busy
    a_r5_soft_type: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_in.proc && !busy_q) |=> (type_q == RT_SOFT && busy_q));

    // R4: the early assertion window never outlives the busy flag
    a_r4_pend_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> busy_q);
endmodule

// File: rtl/rstseq_slow.sv
// Slow-clock side: sequences software and watchdog reset states,
// and stretches the external pin pulse to 2^(len+1) cycles.
// Assumes: wdt_fault is synchronous to clk. cmd and len are static
// while a request toggle is in flight.
module rstseq_slow
    import rstseq_pkg::*;
#(
    parameter int LEN_W    = 4,
    parameter int RST_CYC  = 3,
    parameter int SYNC_STG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_tgl,
    input  rst_cmd_t         cmd,
    input  logic [LEN_W-1:0] len,
    input  logic             wdt_fault,
    input  logic             wdt_proc_only,
    output logic             proc_o,
    output logic             per_o,
    output logic             ext_n_o,
    output logic             sw_act_o,
    output logic             wd_tgl_o
);
    localparam int CNT_W = (1 << LEN_W) + 1;
    localparam int CYC_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
    localparam logic [CYC_W-1:0] LAST = CYC_W'(RST_CYC - 1);

    sq_state_e        state_q;
    logic [CYC_W-1:0] cnt_q;
    logic [CNT_W-1:0] ext_cnt_q;
    logic req_s, req_d_q, req_pend_q, wd_pend_q, wd_po_q;
    logic req_evt, take_sw, take_wd, po_now, enter_sw, enter_wd, start_ext;

    rstseq_sync #(.STAGES(SYNC_STG)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
    );

    assign req_evt   = req_s ^ req_d_q;
    assign take_sw   = req_evt || req_pend_q;
    assign take_wd   = wdt_fault || wd_pend_q;
    assign po_now    = wdt_fault ? wdt_proc_only : wd_po_q;
    assign enter_sw  = (state_q == SQ_IDLE) && take_sw;
    assign enter_wd  = (state_q == SQ_IDLE) && !take_sw && take_wd;
    assign start_ext = (enter_sw && cmd.ext) || (enter_wd && !po_now);

    // Request edge history
    always_ff @(posedge clk) begin
        if (!rst_n) req_d_q <= 1'b0;
        else        req_d_q <= req_s;
    end

    // State sequencer with pending software and watchdog requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SQ_IDLE;
            cnt_q      <= '0;
            proc_o     <= 1'b0;
            per_o      <= 1'b0;
            req_pend_q <= 1'b0;
            wd_pend_q  <= 1'b0;
            wd_po_q    <= 1'b0;
            wd_tgl_o   <= 1'b0;
        end else begin
            if (req_evt) req_pend_q <= 1'b1;
            if (wdt_fault) begin
                wd_pend_q <= 1'b1;
                wd_po_q   <= wdt_proc_only;
            end
            case (state_q)
                SQ_IDLE: begin
                    if (enter_sw) begin
                        state_q    <= SQ_SW;
                        cnt_q      <= '0;
                        proc_o     <= cmd.proc;
                        per_o      <= cmd.per;
                        req_pend_q <= 1'b0;
                    end else if (enter_wd) begin
                        state_q   <= SQ_WD;
                        cnt_q     <= '0;
                        proc_o    <= 1'b1;
                        per_o     <= !po_now;
                        wd_pend_q <= 1'b0;
                        wd_tgl_o  <= ~wd_tgl_o;
                    end
                end
                default: begin
                    if (cnt_q == LAST) begin
                        state_q <= SQ_IDLE;
                        proc_o  <= 1'b0;
                        per_o   <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // External pin stretcher: loads 2^(len+1) and counts down
    always_ff @(posedge clk) begin
        if (!rst_n)                ext_cnt_q <= '0;
        else if (start_ext)        ext_cnt_q <= CNT_W'(1) << (int'(len) + 1);
        else if (ext_cnt_q != '0)  ext_cnt_q <= ext_cnt_q - 1'b1;
    end

    assign ext_n_o  = (ext_cnt_q == '0);
    assign sw_act_o = (state_q == SQ_SW);

    // R3: the software state ends after its last counted cycle
    a_r3_sw_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_SW && cnt_q == LAST) |=> (state_q != SQ_SW));

    // R8: the watchdog state ends after its last counted cycle
    a_r8_wd_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_WD && cnt_q == LAST) |=> (state_q == SQ_IDLE && !proc_o));

    // R6: the pin is released once the final count has elapsed
    a_r6_ext_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cnt_q == CNT_W'(1) && !start_ext) |=> ext_n_o);

    // R11: a fault during a software reset is held for later
    a_r11_wd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_SW && wdt_fault) |=> wd_pend_q);

    // R9: processor-only watchdog entry leaves the peripheral reset off
    a_r9_proc_only: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_wd && po_now) |=> (proc_o && !per_o));
endmodule

// File: rtl/rstseq_top.sv
// Reset controller sequencer top: ties the master-clock command side
// to the slow-clock sequencer through toggle and level synchronisers.
// Assumes: mck is faster than slck, and wdt_fault is synchronous to slck.
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int LEN_W    = 4,
    parameter int RST_CYC  = 3,
    parameter int SYNC_STG = 2
) (
    input  logic             mck,
    input  logic             mck_rst_n,
    input  logic             slck,
    input  logic             slck_rst_n,
    input  logic             cmd_we,
    input  logic             cmd_proc,
    input  logic             cmd_periph,
    input  logic             cmd_ext,
    input  logic             mode_we,
    input  logic [LEN_W-1:0] mode_len,
    input  logic             wdt_fault,
    input  logic             wdt_proc_only,
    output logic             proc_rst_n,
    output logic             periph_rst_n,
    output logic             ext_rst_n,
    output logic             ext_self_low,
    output logic             stat_busy,
    output logic [2:0]       stat_type
);
    rst_cmd_t         cmd_in, cmd_q;
    logic             pend_q, req_tgl, sw_act, sw_act_s, wd_tgl, wd_tgl_s;
    logic             s_proc, s_per, s_ext_n;
    logic [LEN_W-1:0] len_q;
    logic [TYPE_W-1:0] type_q;

    assign cmd_in = '{proc: cmd_proc, per: cmd_periph, ext: cmd_ext};

    rstseq_cmd #(.LEN_W(LEN_W)) u_cmd (
        .clk(mck), .rst_n(mck_rst_n), .cmd_we(cmd_we), .cmd_in(cmd_in),
        .mode_we(mode_we), .mode_len(mode_len), .sw_act_s(sw_act_s),
        .wd_tgl_s(wd_tgl_s), .cmd_q(cmd_q), .pend_q(pend_q),
        .req_tgl_q(req_tgl), .busy_q(stat_busy), .type_q(type_q),
        .len_q(len_q)
    );

    rstseq_sync #(.STAGES(SYNC_STG)) u_act_sync (
        .clk(mck), .rst_n(mck_rst_n), .d(sw_act), .q(sw_act_s)
    );

    rstseq_sync #(.STAGES(SYNC_STG)) u_wd_sync (
        .clk(mck), .rst_n(mck_rst_n), .d(wd_tgl), .q(wd_tgl_s)
    );

    rstseq_slow #(.LEN_W(LEN_W), .RST_CYC(RST_CYC), .SYNC_STG(SYNC_STG)) u_slow (
        .clk(slck), .rst_n(slck_rst_n), .req_tgl(req_tgl), .cmd(cmd_q),
        .len(len_q), .wdt_fault(wdt_fault), .wdt_proc_only(wdt_proc_only),
        .proc_o(s_proc), .per_o(s_per), .ext_n_o(s_ext_n),
        .sw_act_o(sw_act), .wd_tgl_o(wd_tgl)
    );

    // Early mck-side assertion merged with slow-side hold
    assign proc_rst_n   = !((pend_q && cmd_q.proc) || s_proc);
    assign periph_rst_n = !((pend_q && cmd_q.per) || s_per);
    assign ext_rst_n    = s_ext_n;
    assign ext_self_low = !s_ext_n;
    assign stat_type    = type_q;
endmodule

// File: tb/rstseq_top_tb.sv
module rstseq_top_tb;
    localparam int MCK_P  = 10;
    localparam int SLCK_P = 70;
    localparam int LEN_W  = 4;

    logic mck = 0, slck = 0, mck_rst_n = 0, slck_rst_n = 0;
    logic cmd_we = 0, cmd_proc = 0, cmd_periph = 0, cmd_ext = 0;
    logic mode_we = 0;
    logic [LEN_W-1:0] mode_len = '0;
    logic wdt_fault = 0, wdt_proc_only = 0;
    logic proc_rst_n, periph_rst_n, ext_rst_n, ext_self_low, stat_busy;
    logic [2:0] stat_type;

    int total = 0, bad = 0;
    int lp = 0, lper = 0, lext = 0, lself = 0, fp = 0;
    logic prevp = 1'b1;
    int s_lp, s_lper, s_lext, s_lself, s_fp;
    int exp_type = 0;

    always #(MCK_P/2)  mck  = ~mck;
    always #(SLCK_P/2) slck = ~slck;

    rstseq_top #(.LEN_W(LEN_W)) u_dut (
        .mck(mck), .mck_rst_n(mck_rst_n), .slck(slck), .slck_rst_n(slck_rst_n),
        .cmd_we(cmd_we), .cmd_proc(cmd_proc), .cmd_periph(cmd_periph),
        .cmd_ext(cmd_ext), .mode_we(mode_we), .mode_len(mode_len),
        .wdt_fault(wdt_fault), .wdt_proc_only(wdt_proc_only),
        .proc_rst_n(proc_rst_n), .periph_rst_n(periph_rst_n),
        .ext_rst_n(ext_rst_n), .ext_self_low(ext_self_low),
        .stat_busy(stat_busy), .stat_type(stat_type)
    );

    // Slow-cycle low counters, sampled away from the active edge
    always @(negedge slck) begin
        if (slck_rst_n) begin
            if (!proc_rst_n)   lp++;
            if (!periph_rst_n) lper++;
            if (!ext_rst_n)    lext++;
            if (ext_self_low)  lself++;
            if (prevp && !proc_rst_n) fp++;
            prevp = proc_rst_n;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic snap();
        s_lp = lp; s_lper = lper; s_lext = lext; s_lself = lself; s_fp = fp;
    endtask

    task automatic wr_cmd(input bit p, input bit r, input bit e);
        @(negedge mck);
        cmd_we = 1; cmd_proc = p; cmd_periph = r; cmd_ext = e;
        @(negedge mck);
        cmd_we = 0; cmd_proc = 0; cmd_periph = 0; cmd_ext = 0;
    endtask

    task automatic wr_mode(input int l);
        @(negedge mck);
        mode_we = 1; mode_len = LEN_W'(l);
        @(negedge mck);
        mode_we = 0;
    endtask

    task automatic fault(input bit po);
        @(negedge slck);
        wdt_fault = 1; wdt_proc_only = po;
        @(negedge slck);
        wdt_fault = 0; wdt_proc_only = 0;
    endtask

    task automatic settle();
        wait (stat_busy == 1'b0);
        repeat (40) @(negedge slck);
        @(negedge mck);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(MCK_P * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge slck);
        mck_rst_n = 1; slck_rst_n = 1;
        repeat (3) @(negedge slck);
        @(negedge mck);
        // R1 reset state
        chk(proc_rst_n && periph_rst_n && ext_rst_n, "R1 outputs high", {proc_rst_n, periph_rst_n, ext_rst_n}, 7);
        chk(!stat_busy, "R1 busy", stat_busy, 0);
        chk(stat_type == 0, "R1 type", stat_type, 0);

        // R2 all-zero write has no effect
        wr_cmd(0, 0, 0);
        chk(!stat_busy && proc_rst_n && periph_rst_n, "R2 zero write", stat_busy, 0);

        // Sweep every non-zero command combination, pin length code 1
        wr_mode(1);
        for (int c = 1; c < 8; c++) begin
            bit p, r, e;
            p = c[2]; r = c[1]; e = c[0];
            snap();
            wr_cmd(p, r, e);
            chk(proc_rst_n == !p, "R2 proc immediate", proc_rst_n, !p);
            chk(periph_rst_n == !r, "R2 periph immediate", periph_rst_n, !r);
            chk(stat_busy, "R4 busy set", stat_busy, 1);
            if (p) exp_type = 3;
            chk(stat_type == exp_type, "R5 type", stat_type, exp_type);
            settle();
            if (p) chk((lp - s_lp) >= 4 && (lp - s_lp) <= 6, "R3 proc low", lp - s_lp, 5);
            else   chk(lp == s_lp, "R2 proc untouched", lp - s_lp, 0);
            if (r) chk((lper - s_lper) >= 4 && (lper - s_lper) <= 6, "R3 periph low", lper - s_lper, 5);
            else   chk(lper == s_lper, "R2 periph untouched", lper - s_lper, 0);
            chk((lext - s_lext) == (e ? 4 : 0), "R6 ext length", lext - s_lext, e ? 4 : 0);
            chk((lself - s_lself) == (lext - s_lext), "R7 self low", lself - s_lself, lext - s_lext);
            chk(!stat_busy, "R4 busy cleared", stat_busy, 0);
        end

        // R6 length sweep on the pin
        for (int l = 0; l < 4; l++) begin
            wr_mode(l);
            snap();
            wr_cmd(0, 0, 1);
            settle();
            chk((lext - s_lext) == (2 << l), "R6 length sweep", lext - s_lext, 2 << l);
            chk((lself - s_lself) == (2 << l), "R7 self low sweep", lself - s_lself, 2 << l);
        end

        // R8 watchdog, full reset, length code 2
        wr_mode(2);
        snap();
        fault(0);
        settle();
        chk((lp - s_lp) == 3, "R8 proc low", lp - s_lp, 3);
        chk((lper - s_lper) == 3, "R8 periph low", lper - s_lper, 3);
        chk((lext - s_lext) == 8, "R8 ext low", lext - s_lext, 8);
        chk(stat_type == 2, "R10 type", stat_type, 2);
        chk(!stat_busy, "R8 busy untouched", stat_busy, 0);

        // R9 watchdog, processor only
        snap();
        fault(1);
        settle();
        chk((lp - s_lp) == 3, "R9 proc low", lp - s_lp, 3);
        chk(lper == s_lper, "R9 periph idle", lper - s_lper, 0);
        chk(lext == s_lext, "R9 ext idle", lext - s_lext, 0);
        chk(stat_type == 2, "R10 type again", stat_type, 2);

        // R4 write while busy is ignored
        snap();
        wr_cmd(0, 1, 0);
        wr_cmd(1, 0, 1);
        chk(proc_rst_n, "R4 proc ignored now", proc_rst_n, 1);
        settle();
        chk(lp == s_lp, "R4 proc ignored", lp - s_lp, 0);
        chk(lext == s_lext, "R4 ext ignored", lext - s_lext, 0);
        chk(stat_type == 2, "R4 type kept", stat_type, 2);

        // R11 watchdog fault landing inside a software reset
        snap();
        wr_cmd(1, 1, 0);
        repeat (3) @(posedge slck);
        fault(0);
        settle();
        chk((fp - s_fp) == 2, "R11 two periods", fp - s_fp, 2);
        chk((lp - s_lp) >= 7 && (lp - s_lp) <= 9, "R11 proc low total", lp - s_lp, 8);
        chk((lext - s_lext) == 8, "R11 ext from watchdog", lext - s_lext, 8);
        chk(stat_type == 2, "R11 R10 type", stat_type, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule